// File: doc/BRIEF.md
# Conditional Skip Squash Sequencer

This block sits in an instruction issue path, beside the decoder. When a test instruction finds its skip condition true, it raises a one-cycle skip request. The sequencer then marks the instructions that follow for squashing.

Every consecutive page-select or bank-select prefix is squashed, and so is the first non-prefix instruction after them. Each squashed instruction takes the one issue slot it would have used anyway. When the skip condition is false, nothing is squashed and the test instruction costs a single cycle.

The instruction stream arrives as one beat per cycle, qualified by `ins_valid`. The block applies no back-pressure: every valid beat is consumed in the cycle it is presented. A cycle with `ins_valid` low is a bubble. A bubble neither advances nor ends a squash run.

The `squash` output is combinational on the current beat. The state, the busy flag and the per-event squash count are registered.

Top module: `skip_squash_seq`

## Requirements
- R1: A synchronous reset, `rst` high at a clock edge, leaves `busy` low and `squash_cnt` at zero, with `squash` low while idle.
- R2: Without an accepted skip request, no beat is squashed. The beat presented with `skip_req` is the test instruction itself and is never squashed by that request.
- R3: After an accepted skip, the next valid ordinary beat is squashed. After that clock edge `busy` is low and issue resumes unsquashed.
- R4: After an accepted skip, a single page (code 1) or bank (code 2) prefix beat and the ordinary beat after it are both squashed. Together with the test beat this is three cycles.
- R5: Any run of consecutive page and bank prefixes after an accepted skip is squashed in full, together with the first non-prefix beat. Codes 0 (ordinary) and 3 (reserved) are both non-prefix.
- R6: A cycle with `ins_valid` low has `squash` low and leaves `busy` and `squash_cnt` unchanged.
- R7: A `skip_req` that arrives while `busy` is high is ignored. It does not restart the count and does not extend the run.
- R8: `squash_cnt` clears to zero on the edge that accepts a skip. It adds one on each squashed beat, and holds its value after the run ends until the next accepted skip.
- R9: `squash_cnt` saturates at its all-ones value (255 for the default 8-bit width) and does not wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| skip_req | input | 1 | Skip condition true for the beat presented this cycle |
| ins_valid | input | 1 | A decoded instruction beat is present |
| ins_cls | input | 2 | Beat class: 0 ordinary, 1 page prefix, 2 bank prefix, 3 reserved (treated as ordinary) |
| squash | output | 1 | The present beat must be dropped |
| busy | output | 1 | A squash run is in progress |
| squash_cnt | output | CNT_W | Squashed beats counted for the latest skip event |

## Verification
`squash` belongs to the beat on the inputs in the same cycle. The bench drives each beat just after a falling edge and reads `squash` late in that same half-period, before the next rising edge.

`busy` and `squash_cnt` change one register stage after the beat that causes the change. Each table row therefore carries the values expected to be visible before that row's edge, that is, the result of all earlier rows.

The directed reset and saturation tests read state one cycle after the last stimulus edge, in the same way.

// File: rtl/skip_squash_pkg.sv
package skip_squash_pkg;

  typedef enum logic [1:0] {
    CLS_ORD  = 2'd0,
    CLS_PAGE = 2'd1,
    CLS_BANK = 2'd2,
    CLS_RSV  = 2'd3
  } ins_cls_e;

  typedef enum logic {
    ST_ISSUE  = 1'b0,
    ST_SQUASH = 1'b1
  } sq_state_e;

endpackage

// File: rtl/skip_cls_decode.sv
module skip_cls_decode
  import skip_squash_pkg::*;
(
  input  logic [1:0] cls,
  output logic       is_prefix
);

  always_comb begin
    unique case (ins_cls_e'(cls))
      CLS_PAGE, CLS_BANK: is_prefix = 1'b1;
      default:            is_prefix = 1'b0;
    endcase
  end

endmodule

// File: rtl/skip_squash_fsm.sv
module skip_squash_fsm
  import skip_squash_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic skip_req,
  input  logic beat_valid,
  input  logic beat_prefix,
  output logic accept,
  output logic squash,
  output logic active
);

  sq_state_e state_q, state_d;

  assign active = (state_q == ST_SQUASH);
  assign accept = !active && skip_req;
  assign squash = active && beat_valid;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_ISSUE:  if (skip_req) state_d = ST_SQUASH;
      ST_SQUASH: if (beat_valid && !beat_prefix) state_d = ST_ISSUE;
      default:   state_d = ST_ISSUE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state_q <= ST_ISSUE;
    else     state_q <= state_d;
  end

endmodule

// File: rtl/skip_len_counter.sv
module skip_len_counter #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear,
  input  logic             inc,
  output logic [CNT_W-1:0] count
);

  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  always_ff @(posedge clk) begin
    if (rst || clear)               count <= '0;
    else if (inc && count != CNT_MAX) count <= count + 1'b1;
  end

endmodule

// File: rtl/skip_squash_seq.sv
module skip_squash_seq #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             skip_req,
  input  logic             ins_valid,
  input  logic [1:0]       ins_cls,
  output logic             squash,
  output logic             busy,
  output logic [CNT_W-1:0] squash_cnt
);

  logic is_prefix;
  logic accept;

  skip_cls_decode u_dec (
    .cls       (ins_cls),
    .is_prefix (is_prefix)
  );

  skip_squash_fsm u_fsm (
    .clk         (clk),
    .rst         (rst),
    .skip_req    (skip_req),
    .beat_valid  (ins_valid),
    .beat_prefix (is_prefix),
    .accept      (accept),
    .squash      (squash),
    .active      (busy)
  );

  skip_len_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk   (clk),
    .rst   (rst),
    .clear (accept),
    .inc   (squash),
    .count (squash_cnt)
  );

endmodule

// File: rtl/skip_squash_seq_chk.sv
module skip_squash_seq_chk #(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             skip_req,
  input logic             ins_valid,
  input logic [1:0]       ins_cls,
  input logic             squash,
  input logic             busy,
  input logic [CNT_W-1:0] squash_cnt
);

  logic nonprefix;
  assign nonprefix = (ins_cls == 2'd0) || (ins_cls == 2'd3);

  a_r1_reset_clears: assert property (@(posedge clk)
    rst |=> (!busy && squash_cnt == '0));

  a_r2_idle_no_squash: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !squash);

  a_r3_run_ends: assert property (@(posedge clk) disable iff (rst)
    (busy && ins_valid && nonprefix) |=> !busy);

  a_r5_prefix_keeps: assert property (@(posedge clk) disable iff (rst)
    (busy && ins_valid && !nonprefix) |=> busy);

  a_r6_bubble_holds: assert property (@(posedge clk) disable iff (rst)
    (busy && !ins_valid) |=> (busy && $stable(squash_cnt)));

  a_r7_ignore_retrigger: assert property (@(posedge clk) disable iff (rst)
    (busy && skip_req && !ins_valid) |=> $stable(squash_cnt));

  a_r8_count_step: assert property (@(posedge clk) disable iff (rst)
    (squash && squash_cnt != {CNT_W{1'b1}}) |=> squash_cnt == $past(squash_cnt) + 1'b1);

  a_r9_saturate: assert property (@(posedge clk) disable iff (rst)
    (busy && squash_cnt == {CNT_W{1'b1}}) |=> squash_cnt == {CNT_W{1'b1}});

endmodule

bind skip_squash_seq skip_squash_seq_chk #(.CNT_W(CNT_W)) u_chk (.*);

// File: tb/test_skip_squash_seq.sv
module test_skip_squash_seq;

  logic       clk = 1'b0;
  logic       rst;
  logic       skip_req;
  logic       ins_valid;
  logic [1:0] ins_cls;
  logic       squash;
  logic       busy;
  logic [7:0] squash_cnt;

  int n_chk = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  skip_squash_seq i_skip_squash_seq (
    .clk(clk), .rst(rst), .skip_req(skip_req), .ins_valid(ins_valid),
    .ins_cls(ins_cls), .squash(squash), .busy(busy), .squash_cnt(squash_cnt)
  );

  // {skip, valid, cls[1:0], exp_squash, exp_busy, exp_cnt[3:0]}
  localparam int NV = 15;
  localparam logic [9:0] VEC [NV] = '{
    {1'b1,1'b1,2'd0,1'b0,1'b0,4'd0},  // R2 test beat not squashed
    {1'b0,1'b1,2'd0,1'b1,1'b1,4'd0},  // R3 ordinary squashed
    {1'b0,1'b1,2'd0,1'b0,1'b0,4'd1},  // R3 resumes
    {1'b1,1'b1,2'd0,1'b0,1'b0,4'd1},
    {1'b0,1'b1,2'd1,1'b1,1'b1,4'd0},  // R4 page prefix
    {1'b0,1'b1,2'd0,1'b1,1'b1,4'd1},  // R4 following ordinary
    {1'b0,1'b1,2'd0,1'b0,1'b0,4'd2},
    {1'b1,1'b1,2'd0,1'b0,1'b0,4'd2},
    {1'b0,1'b1,2'd2,1'b1,1'b1,4'd0},  // R5 bank
    {1'b0,1'b0,2'd1,1'b0,1'b1,4'd1},  // R6 bubble
    {1'b0,1'b1,2'd1,1'b1,1'b1,4'd1},  // R5 page
    {1'b1,1'b1,2'd2,1'b1,1'b1,4'd2},  // R7 retrigger ignored
    {1'b0,1'b1,2'd3,1'b1,1'b1,4'd3},  // R5 reserved ends run
    {1'b0,1'b1,2'd0,1'b0,1'b0,4'd4},  // R8 count held
    {1'b0,1'b0,2'd0,1'b0,1'b0,4'd4}
  };

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic drive(input logic s, input logic v, input logic [1:0] c);
    @(negedge clk);
    skip_req = s; ins_valid = v; ins_cls = c;
    #3;
  endtask

  initial begin
    #200000;
    n_fail++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst = 1'b1; skip_req = 1'b0; ins_valid = 1'b0; ins_cls = 2'd0;
    repeat (2) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    #3;
    check("R1 busy", int'(busy), 0);
    check("R1 cnt", int'(squash_cnt), 0);
    check("R1 squash", int'(squash), 0);

    for (int i = 0; i < NV; i++) begin
      drive(VEC[i][9], VEC[i][8], VEC[i][7:6]);
      check($sformatf("R2-R8 row%0d squash", i), int'(squash), int'(VEC[i][5]));
      check($sformatf("R2-R8 row%0d busy", i), int'(busy), int'(VEC[i][4]));
      check($sformatf("R8 row%0d cnt", i), int'(squash_cnt), int'(VEC[i][3:0]));
    end

    // R1: reset in the middle of a run
    drive(1'b1, 1'b1, 2'd0);
    drive(1'b0, 1'b1, 2'd1);
    check("R1 pre-reset busy", int'(busy), 1);
    @(negedge clk); rst = 1'b1; skip_req = 1'b0; ins_valid = 1'b0;
    @(negedge clk); rst = 1'b0;
    #3;
    check("R1 mid-run busy", int'(busy), 0);
    check("R1 mid-run cnt", int'(squash_cnt), 0);
    drive(1'b0, 1'b1, 2'd0);
    check("R1 R2 after reset squash", int'(squash), 0);

    // R9: long prefix chain saturates the count
    drive(1'b1, 1'b1, 2'd0);
    for (int k = 0; k < 300; k++) drive(1'b0, 1'b1, (k % 2 == 0) ? 2'd1 : 2'd2);
    check("R9 still busy", int'(busy), 1);
    check("R9 saturated", int'(squash_cnt), 255);
    drive(1'b0, 1'b1, 2'd0);
    check("R5 final squash", int'(squash), 1);
    drive(1'b0, 1'b0, 2'd0);
    check("R3 idle after chain", int'(busy), 0);
    check("R9 held", int'(squash_cnt), 255);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule